// File: doc/BRIEF.md
# CPU Address Window Decoder

This block compares a 32-bit CPU address against a bank of programmable target windows and reports which one the address falls in. The windows are ordered by index: memory chip selects come first, then device chip selects, then a single boot chip select, and then one group per external bus interface. Each bus group holds an I/O window followed by its memory windows. With the default parameters there are 4 + 4 + 1 + 2 × 5 = 19 windows, so the indices run 0–3, 4–7, 8, 9–13 and 14–18.

Each window has a 16-bit base, which holds address bits [31:16], and a 16-bit size mask. The mask holds the window length in 64 KB units minus one. A shared disable bitmap switches windows on and off, with one bit per window. Bus windows also carry a low and a high remap register, which together produce a 64-bit outbound address.

Addresses come in on a valid/ready stream and the decode result leaves on another valid/ready stream after one register stage. The input can be accepted only when the output stage is empty or is being drained in the same cycle. Back-pressure from `out_ready` therefore stalls the input directly, and the held result stays unchanged until it is taken. Configuration uses a plain write port with no handshake.

Top module: `addr_window_decoder`

## Requirements
- R1: An address hits window w when `addr[31:16] & ~mask[w]` equals `base[w]`. The mask value is (window bytes >> 16) - 1, so a mask of 0x00FF covers 16 MB.
- R2: A window can hit only when all three of these hold:
  - its mask is a run of ones starting at bit 0 with zeros above;
  - its mask is at least 0x000F (1 MB);
  - `base & mask` is zero.
  A mask of 0xFFFF (4 GB) is legal. Any other window never hits.
- R3: In the disable bitmap, bit w = 1 closes window w, so a closed window never hits. After reset every bit is 1.
- R4: The write kind selects how `cfg_wr_data[NUM_WIN-1:0]` acts on the disable bitmap, and one write can affect several windows:
  - kind 4 loads the bitmap;
  - kind 5 sets the bitmap bits where the data is 1;
  - kind 6 clears the bitmap bits where the data is 1.
- R5: When several windows hit, `out_hit` is one-hot on the lowest index and `out_overlap` is 1. With a single hit, `out_overlap` is 0.
- R6: When no window hits, `out_miss` is 1, `out_hit` is all zeros and `out_addr` is `{32'h0, addr}`.
- R7: A hit on a bus window (index >= NUM_MEM+NUM_DEV+1) gives the outbound address `{rhi, (rlo & ~mask) | (addr[31:16] & mask), addr[15:0]}`. A hit on any other window gives `{32'h0, addr}`.
- R8: The result of an address accepted at clock edge k appears with `out_valid` = 1 after edge k. `in_ready` = `!out_valid || out_ready`. While `out_valid && !out_ready`, the result holds stable.
- R9: Register writes take effect at the next clock edge. An address accepted at the same edge as a write is decoded with the old values. The write kinds are:
  - 0: base, taken from data[15:0];
  - 1: mask, taken from data[15:0];
  - 2: remap low, taken from data[15:0];
  - 3: remap high, taken from data[31:0].
  Remap writes to non-bus windows are ignored.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_kind | input | 3 | Write kind (see R4, R9) |
| cfg_wr_idx | input | IDX_W | Window index of the write |
| cfg_wr_data | input | 32 | Write data |
| in_valid | input | 1 | Address valid |
| in_ready | output | 1 | Address accepted when high with in_valid |
| in_addr | input | 32 | CPU address |
| out_valid | output | 1 | Decode result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | NUM_WIN | One-hot selected window |
| out_miss | output | 1 | No enabled window matched |
| out_overlap | output | 1 | Two or more windows matched |
| out_addr | output | 64 | Outbound address |

## Verification
The bench targets these corner cases:
- the top byte of a window and the first byte past its end, where a wrong mask polarity or an off-by-one would move the boundary;
- a size mask with a hole in it, a mask below 1 MB and a misaligned base, each of which a lax decoder would wrongly accept;
- nested windows, where a wrong priority order picks the higher index and a missing overlap flag stays silent.

For remapping, the bench uses a bus window whose remap bits overlap the bits under the mask; taking the wrong source for either field shows up in the outbound address. A write issued in the same cycle as an address shows whether the decoder wrongly forwards the new value. A burst of addresses under irregular back-pressure exposes lost, duplicated or changed results.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

  typedef enum logic [2:0] {
    WK_BASE  = 3'd0,
    WK_MASK  = 3'd1,
    WK_RLO   = 3'd2,
    WK_RHI   = 3'd3,
    WK_DLOAD = 3'd4,
    WK_DSET  = 3'd5,
    WK_DCLR  = 3'd6,
    WK_NONE  = 3'd7
  } wr_kind_e;

  localparam int          PAGE_W   = 16;
  localparam logic [15:0] MIN_MASK = 16'h000F;  // 1 MB in 64 KB pages, minus one

  // Contiguous ones from bit 0, and covering at least the minimum window.
  function automatic logic mask_legal(input logic [PAGE_W-1:0] m);
    return ((m & (m + 16'd1)) == '0) && ((m & MIN_MASK) == MIN_MASK);
  endfunction

endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = 19,
  parameter int BUS_FIRST = 9,
  localparam int IDX_W    = $clog2(NUM_WIN),
  localparam int NUM_BUS  = NUM_WIN - BUS_FIRST
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [2:0]                       wr_kind,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [31:0]                      wr_data,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]   base_o,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]   mask_o,
  output logic [NUM_WIN-1:0]               dis_o,
  output logic [NUM_BUS-1:0][PAGE_W-1:0]   rlo_o,
  output logic [NUM_BUS-1:0][31:0]         rhi_o
);

  wr_kind_e kind;
  assign kind = wr_kind_e'(wr_kind);

  logic [NUM_WIN-1:0][PAGE_W-1:0] base_q, mask_q;
  logic [NUM_WIN-1:0]             dis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (wr_idx == IDX_W'(w)) begin
          if (kind == WK_BASE) base_q[w] <= wr_data[PAGE_W-1:0];
          if (kind == WK_MASK) mask_q[w] <= wr_data[PAGE_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= '1;
    end else if (wr_en) begin
      case (kind)
        WK_DLOAD: dis_q <= wr_data[NUM_WIN-1:0];
        WK_DSET:  dis_q <= dis_q | wr_data[NUM_WIN-1:0];
        WK_DCLR:  dis_q <= dis_q & ~wr_data[NUM_WIN-1:0];
        default:  dis_q <= dis_q;
      endcase
    end
  end

  // Remap storage exists only for bus windows.
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_remap
    logic [PAGE_W-1:0] rlo_q;
    logic [31:0]       rhi_q;
    logic              sel;
    assign sel = wr_en && (wr_idx == IDX_W'(BUS_FIRST + b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rlo_q <= '0;
        rhi_q <= '0;
      end else if (sel) begin
        if (kind == WK_RLO) rlo_q <= wr_data[PAGE_W-1:0];
        if (kind == WK_RHI) rhi_q <= wr_data;
      end
    end
    assign rlo_o[b] = rlo_q;
    assign rhi_o[b] = rhi_q;
  end

  assign base_o = base_q;
  assign mask_o = mask_q;
  assign dis_o  = dis_q;

endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 19
) (
  input  logic [PAGE_W-1:0]              addr_hi,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0] base_i,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0] mask_i,
  input  logic [NUM_WIN-1:0]             dis_i,
  output logic [NUM_WIN-1:0]             raw_hit_o
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic legal, cmp;
    assign legal = mask_legal(mask_i[w]) && ((base_i[w] & mask_i[w]) == '0);
    assign cmp   = (addr_hi & ~mask_i[w]) == base_i[w];
    assign raw_hit_o[w] = !dis_i[w] && legal && cmp;
  end

endmodule

// File: rtl/addr_win_prio.sv
module addr_win_prio #(
  parameter int NUM_WIN = 19
) (
  input  logic [NUM_WIN-1:0] raw_i,
  output logic [NUM_WIN-1:0] grant_o,
  output logic               any_o,
  output logic               multi_o
);

  // Lowest set bit wins; more than one set bit flags an overlap.
  assign grant_o = raw_i & (~raw_i + NUM_WIN'(1));
  assign any_o   = |raw_i;
  assign multi_o = (raw_i & (raw_i - NUM_WIN'(1))) != '0;

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import addr_win_pkg::*;
#(
  parameter int NUM_MEM     = 4,
  parameter int NUM_DEV     = 4,
  parameter int NUM_BUSIF   = 2,
  parameter int BUS_MEM_WIN = 4,
  localparam int BUS_FIRST  = NUM_MEM + NUM_DEV + 1,
  localparam int NUM_WIN    = BUS_FIRST + NUM_BUSIF * (1 + BUS_MEM_WIN),
  localparam int NUM_BUS    = NUM_WIN - BUS_FIRST,
  localparam int IDX_W      = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [2:0]         cfg_wr_kind,
  input  logic [IDX_W-1:0]   cfg_wr_idx,
  input  logic [31:0]        cfg_wr_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_addr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [NUM_WIN-1:0] out_hit,
  output logic               out_miss,
  output logic               out_overlap,
  output logic [63:0]        out_addr
);

  logic [NUM_WIN-1:0][PAGE_W-1:0] base_w, mask_w;
  logic [NUM_WIN-1:0]             dis_w;
  logic [NUM_BUS-1:0][PAGE_W-1:0] rlo_w;
  logic [NUM_BUS-1:0][31:0]       rhi_w;
  logic [NUM_WIN-1:0]             raw_w, grant_w;
  logic                           any_w, multi_w;
  logic [63:0]                    nxt_addr;

  addr_win_regs #(.NUM_WIN(NUM_WIN), .BUS_FIRST(BUS_FIRST)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_kind (cfg_wr_kind),
    .wr_idx  (cfg_wr_idx),
    .wr_data (cfg_wr_data),
    .base_o  (base_w),
    .mask_o  (mask_w),
    .dis_o   (dis_w),
    .rlo_o   (rlo_w),
    .rhi_o   (rhi_w)
  );

  addr_win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr_hi   (in_addr[31:16]),
    .base_i    (base_w),
    .mask_i    (mask_w),
    .dis_i     (dis_w),
    .raw_hit_o (raw_w)
  );

  addr_win_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .raw_i   (raw_w),
    .grant_o (grant_w),
    .any_o   (any_w),
    .multi_o (multi_w)
  );

  // Outbound address: bus windows take remapped upper page bits.
  always_comb begin
    nxt_addr = {32'h0, in_addr};
    for (int b = 0; b < NUM_BUS; b++) begin
      if (grant_w[BUS_FIRST + b]) begin
        nxt_addr = {rhi_w[b],
                    (rlo_w[b] & ~mask_w[BUS_FIRST + b]) |
                    (in_addr[31:16] & mask_w[BUS_FIRST + b]),
                    in_addr[15:0]};
      end
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_hit     <= '0;
      out_miss    <= 1'b0;
      out_overlap <= 1'b0;
      out_addr    <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit     <= grant_w;
        out_miss    <= !any_w;
        out_overlap <= multi_w;
        out_addr    <= nxt_addr;
      end
    end
  end

endmodule

// File: rtl/addr_window_decoder_chk.sv
module addr_window_decoder_chk #(
  parameter int NUM_WIN   = 19,
  parameter int BUS_FIRST = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [NUM_WIN-1:0] out_hit,
  input logic               out_miss,
  input logic               out_overlap,
  input logic [63:0]        out_addr
);

  p_onehot_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_hit));

  p_overlap_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overlap) |-> !out_miss);

  p_miss_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_miss == (out_hit == '0)));

  p_miss_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_addr[63:32] == 32'h0));

  p_nonbus_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_hit[BUS_FIRST-1:0] != '0)) |-> (out_addr[63:32] == 32'h0));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_hit) && $stable(out_addr) &&
       $stable(out_miss) && $stable(out_overlap)));

endmodule

bind addr_window_decoder addr_window_decoder_chk #(
  .NUM_WIN   (NUM_WIN),
  .BUS_FIRST (BUS_FIRST)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_hit     (out_hit),
  .out_miss    (out_miss),
  .out_overlap (out_overlap),
  .out_addr    (out_addr)
);

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NW         = 19;
  localparam int BUSF       = 9;
  localparam int IW         = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [2:0] cfg_wr_kind = 3'd0;
  logic [IW-1:0] cfg_wr_idx = '0;
  logic [31:0] cfg_wr_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_addr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [NW-1:0] out_hit;
  logic out_miss, out_overlap;
  logic [63:0] out_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_decoder dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_kind(cfg_wr_kind),
    .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_miss(out_miss),
    .out_overlap(out_overlap), .out_addr(out_addr)
  );

  typedef struct {
    logic [NW-1:0] hit;
    logic          miss;
    logic          ovl;
    logic [63:0]   addr;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Shadow of programmed state, kept from the requirements.
  logic [15:0] b_m [NW];
  logic [15:0] m_m [NW];
  logic [15:0] rlo_m [NW];
  logic [31:0] rhi_m [NW];
  logic [NW-1:0] dis_m;

  function automatic exp_t predict(input logic [31:0] a, input string tag);
    exp_t e;
    logic [NW-1:0] raw;
    logic [15:0] m;
    int first;
    raw = '0;
    first = -1;
    for (int w = 0; w < NW; w++) begin
      m = m_m[w];
      if (!dis_m[w] && ((m & (m + 16'd1)) == 16'd0) && (m[3:0] == 4'hF) &&
          ((b_m[w] & m) == 16'd0) && ((a[31:16] & ~m) == b_m[w]))
        raw[w] = 1'b1;
    end
    for (int w = NW - 1; w >= 0; w--) if (raw[w]) first = w;
    e.hit  = '0;
    e.miss = (raw == '0);
    e.ovl  = ($countones(raw) > 1);
    e.addr = {32'h0, a};
    if (first >= 0) begin
      e.hit[first] = 1'b1;
      if (first >= BUSF)
        e.addr = {rhi_m[first], (rlo_m[first] & ~m_m[first]) | (a[31:16] & m_m[first]), a[15:0]};
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic model_write(input logic [2:0] k, input int idx, input logic [31:0] d);
    if (idx < NW) begin
      case (k)
        3'd0: b_m[idx] = d[15:0];
        3'd1: m_m[idx] = d[15:0];
        3'd2: if (idx >= BUSF) rlo_m[idx] = d[15:0];
        3'd3: if (idx >= BUSF) rhi_m[idx] = d;
        default: ;
      endcase
    end
    case (k)
      3'd4: dis_m = d[NW-1:0];
      3'd5: dis_m = dis_m | d[NW-1:0];
      3'd6: dis_m = dis_m & ~d[NW-1:0];
      default: ;
    endcase
  endtask

  // Called just after a falling edge.
  task automatic cfg(input logic [2:0] k, input int idx, input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_kind = k; cfg_wr_idx = IW'(idx); cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    model_write(k, idx, d);
  endtask

  task automatic send(input logic [31:0] a, input string tag);
    exp_q.push_back(predict(a, tag));
    in_valid = 1'b1; in_addr = a;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Back-pressure generator
  bit bp_mode = 0;
  int bp_cnt = 0;
  always @(negedge clk) begin
    bp_cnt++;
    out_ready = bp_mode ? ((bp_cnt % 5) > 1) : 1'b1;
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected result: actual=%h expected=none", out_addr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (out_hit !== e.hit || out_miss !== e.miss || out_overlap !== e.ovl || out_addr !== e.addr) begin
          errors++;
          $display("FAIL %s: actual hit=%h miss=%b ovl=%b addr=%h expected hit=%h miss=%b ovl=%b addr=%h",
                   e.tag, out_hit, out_miss, out_overlap, out_addr, e.hit, e.miss, e.ovl, e.addr);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      b_m[w] = '0; m_m[w] = '0; rlo_m[w] = '0; rhi_m[w] = '0;
    end
    dis_m = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", 64'(in_ready), 64'd1);
    @(negedge clk);
    send(32'h1234_5678, "R3 all windows disabled at reset");

    // Window 0: 16 MB at 0
    cfg(3'd0, 0, 32'h0000);
    cfg(3'd1, 0, 32'h00FF);
    send(32'h00AB_CDEF, "R3 window still disabled");
    cfg(3'd6, 0, 32'h1);
    send(32'h00AB_CDEF, "R1 hit inside window 0");
    send(32'h00FF_FFFF, "R1 last byte of window 0");
    send(32'h0100_0000, "R6 first byte past window 0");

    // Window 1 nested in window 0
    cfg(3'd0, 1, 32'h0080);
    cfg(3'd1, 1, 32'h007F);
    cfg(3'd4, 0, 32'(~19'h3));
    send(32'h0090_0000, "R5 nested windows lowest wins");
    send(32'h0010_0000, "R5 single hit no overlap");

    // Illegal masks and bases
    cfg(3'd0, 2, 32'h2000);
    cfg(3'd1, 2, 32'h0005);
    cfg(3'd6, 0, 32'hC);
    send(32'h2000_0000, "R2 mask with hole");
    cfg(3'd1, 2, 32'h0007);
    send(32'h2000_0000, "R2 mask below 1 MB");
    cfg(3'd0, 3, 32'h3010);
    cfg(3'd1, 3, 32'h00FF);
    send(32'h3010_0000, "R2 misaligned base");
    cfg(3'd1, 2, 32'h000F);
    send(32'h2000_0000, "R2 minimum 1 MB window");
    send(32'h2010_0000, "R2 past minimum window");

    // Bus window 10 with remap
    cfg(3'd0, 10, 32'h9000);
    cfg(3'd1, 10, 32'h03FF);
    cfg(3'd2, 10, 32'h1100);
    cfg(3'd3, 10, 32'h0000_0001);
    cfg(3'd6, 0, 32'h400);
    send(32'h9123_4567, "R7 bus remap");
    send(32'h93FF_0001, "R7 bus remap top of window");
    cfg(3'd2, 0, 32'hABCD);
    cfg(3'd3, 0, 32'hFFFF_FFFF);
    send(32'h00AB_CDEF, "R9 remap write to non-bus window ignored");

    // Disable set and clear of several bits at once
    cfg(3'd5, 0, 32'h405);
    send(32'h9123_4567, "R4 set disables bus window");
    send(32'h2000_0000, "R4 set disables window 2");
    send(32'h0090_0000, "R4 set leaves window 1 only");
    cfg(3'd6, 0, 32'h405);
    send(32'h9123_4567, "R4 clear reenables bus window");

    // Write in the same cycle as an address
    exp_q.push_back(predict(32'h2000_0000, "R9 same cycle sees old state"));
    cfg_wr_en = 1'b1; cfg_wr_kind = 3'd5; cfg_wr_idx = '0; cfg_wr_data = 32'h4;
    in_valid = 1'b1; in_addr = 32'h2000_0000;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cfg_wr_en = 1'b0; in_valid = 1'b0;
    model_write(3'd5, 0, 32'h4);
    send(32'h2000_0000, "R9 next cycle sees new state");

    // 4 GB boot window overlapping everything
    cfg(3'd0, 8, 32'h0000);
    cfg(3'd1, 8, 32'hFFFF);
    cfg(3'd6, 0, 32'h100);
    send(32'hF000_0000, "R2 4 GB window");
    send(32'h0010_0000, "R5 low index beats 4 GB window");

    // Burst under back-pressure
    bp_mode = 1;
    send(32'h9123_4567, "R8 burst a");
    send(32'hF000_0000, "R8 burst b");
    send(32'h0090_0000, "R8 burst c");
    send(32'h9000_0000, "R8 burst d");
    send(32'h00AB_CDEF, "R8 burst e");
    send(32'h93FF_FFFF, "R8 burst f");
    send(32'h2000_0000, "R8 burst g");
    send(32'h0100_0000, "R8 burst h");
    repeat (20) @(negedge clk);
    bp_mode = 0;
    for (int i = 0; i < 50; i++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk);
    end
    chk(exp_q.size() == 0, "R8 all results delivered", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule